// File: doc/BRIEF.md
# Reverse-Channel Run-Length Expander

This block sits behind the reverse-direction receive path of a parallel port. Every byte it takes in carries a qualifier: high marks an ordinary data byte, low marks a command byte. A command whose top bit is clear holds a run-length count in its low seven bits. The block stores that count and emits the next data byte count-plus-one times on a valid/ready byte stream. A command whose top bit is set would select a channel address. The block does not support channel addresses, so it discards such a command and raises a one-cycle error pulse.

The control is a three-state machine:
- `S_IDLE`: no count is pending.
- `S_ARMED`: a count is held and waits for its data byte.
- `S_EMIT`: the held byte is being replicated.

Its transitions are:
- `IDLE->ARMED` on an accepted count.
- `IDLE->EMIT` on an accepted data byte, which gives one copy.
- `ARMED->ARMED` on a newer count (it replaces the old one) or on an address command.
- `ARMED->EMIT` on an accepted data byte, which gives count+1 copies.
- `EMIT->IDLE` when the last copy is taken.

All other cases keep the current state. Input acceptance is held off for the whole time the machine is in `S_EMIT`.

Top module: `rle_expand`

## Requirements
- R1: A byte taken with `in_is_data`=1 is data and goes to the output stream; a byte taken with `in_is_data`=0 is a command and never appears on the output.
- R2: A command with bit 7 = 0 holds a count N in bits 6:0, and the next data byte then appears exactly N+1 times on the output, after which `out_valid` falls.
- R3: A count of 0 makes the following data byte appear exactly once.
- R4: A count of 127 makes the following data byte appear exactly 128 times.
- R5: A command with bit 7 = 1 is discarded. `addr_err` is high for the single cycle after that command is taken. Any pending count is left unchanged.
- R6: When a second count arrives before a data byte, only the newer count applies.
- R7: `in_ready` is low whenever `out_valid` is high, and input is taken only when `in_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` holds its value.
- R9: A data byte with no pending count appears exactly once, including a data byte that follows a completed run.
- R10: After reset, `out_valid`=0, `in_ready`=1 and `addr_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take an input byte |
| in_byte | input | 8 | Received byte |
| in_is_data | input | 1 | Qualifier: 1 = data, 0 = command |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the output byte |
| out_byte | output | 8 | Expanded byte stream |
| addr_err | output | 1 | One-cycle pulse for a dropped channel-address command |

## Verification
The assertions assume two things about the consumer and the source. The consumer may stall `out_ready` at any time. The source holds `in_byte` and `in_is_data` steady while `in_valid` is high and `in_ready` is low. The stimulus meets both conditions: it changes the input only on falling edges, and only after the byte has been taken. It drives `out_ready` from a pseudo-random pattern, so stalls land both mid-run and on the last copy. The sweep covers every count from 0 to 127, plus count replacement and address commands in both the idle and the armed state.

// File: rtl/rle_pkg.sv
package rle_pkg;
    typedef enum logic [1:0] {
        K_DATA,
        K_COUNT,
        K_ADDR
    } byte_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARMED,
        S_EMIT
    } rle_state_e;
endpackage

// File: rtl/rle_qual_decode.sv
module rle_qual_decode
    import rle_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              is_data,
    input  logic [DATA_W-1:0] byte_in,
    output byte_kind_e        kind,
    output logic [DATA_W-2:0] count
);
    always_comb begin
        count = byte_in[DATA_W-2:0];
        if (is_data)
            kind = K_DATA;
        else if (byte_in[DATA_W-1])
            kind = K_ADDR;
        else
            kind = K_COUNT;
    end
endmodule

// File: rtl/rle_rep_counter.sv
module rle_rep_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (load)
            left_q <= load_val;
        else if (dec)
            left_q <= left_q - 1'b1;
    end

    assign last = (left_q == '0);
endmodule

// File: rtl/rle_expand.sv
module rle_expand
    import rle_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_is_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_byte,
    output logic              addr_err
);
    localparam int CNT_W = DATA_W - 1;

    rle_state_e       state_q, state_d;
    byte_kind_e       kind;
    logic [CNT_W-1:0] cmd_count;
    logic [CNT_W-1:0] pend_q;
    logic [DATA_W-1:0] hold_q;
    logic             err_q;
    logic             take;
    logic             load_run, dec_run, run_last;
    logic [CNT_W-1:0] run_len;

    rle_qual_decode #(.DATA_W(DATA_W)) u_dec (
        .is_data (in_is_data),
        .byte_in (in_byte),
        .kind    (kind),
        .count   (cmd_count)
    );

    rle_rep_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_run),
        .load_val (run_len),
        .dec      (dec_run),
        .last     (run_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_run  = 1'b0;
        dec_run   = 1'b0;
        run_len   = '0;
        take      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                in_ready = 1'b1;
                take     = in_valid;
                if (take && kind == K_DATA) begin
                    load_run = 1'b1;
                    state_d  = S_EMIT;
                end else if (take && kind == K_COUNT) begin
                    state_d  = S_ARMED;
                end
            end
            S_ARMED: begin
                in_ready = 1'b1;
                take     = in_valid;
                if (take && kind == K_DATA) begin
                    load_run = 1'b1;
                    run_len  = pend_q;
                    state_d  = S_EMIT;
                end
            end
            S_EMIT: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    if (run_last)
                        state_d = S_IDLE;
                    else
                        dec_run = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Data path registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            hold_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= take && (kind == K_ADDR);
            if (take && kind == K_COUNT)
                pend_q <= cmd_count;
            if (take && kind == K_DATA)
                hold_q <= in_byte;
        end
    end

    assign out_byte = hold_q;
    assign addr_err = err_q;
endmodule

// File: rtl/rle_expand_chk.sv
module rle_expand_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_byte,
    input logic              in_is_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_byte,
    input logic              addr_err
);
    // R7: replication blocks the input side
    a_r7_no_take_while_emit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R8: stalled output keeps its byte
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R5: error pulse only after a taken address command
    a_r5_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> $past(in_valid && in_ready && !in_is_data && in_byte[DATA_W-1]));

    // R1: an output run starts only after a data byte is taken
    a_r1_run_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready && in_is_data));

    // R1: a taken command never starts output
    a_r1_cmd_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_is_data) |=> !out_valid);
endmodule

bind rle_expand rle_expand_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_byte    (in_byte),
    .in_is_data (in_is_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_byte   (out_byte),
    .addr_err   (addr_err)
);

// File: tb/sim_rle_expand.sv
`timescale 1ns/1ps
module sim_rle_expand;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = '0;
    logic       in_is_data = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_byte;
    logic       addr_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] lfsr = 8'hA5;

    always #5 clk = ~clk;

    rle_expand u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_is_data(in_is_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_byte(out_byte), .addr_err(addr_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // Send one byte; returns after the edge that takes it, at the next negedge
    task automatic send(input logic [7:0] b, input logic is_data);
        @(negedge clk);
        in_valid   = 1'b1;
        in_byte    = b;
        in_is_data = is_data;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Collect a run and compare its length and bytes; starts at a negedge
    task automatic collect(input logic [7:0] exp_b, input int exp_n, input string req);
        int   got = 0;
        int   guard = 0;
        bit   stalled = 0;
        logic [7:0] seen = '0;
        bit   bad_byte = 0;
        while (got < exp_n && guard < 2000) begin
            if (stalled) begin
                check(out_valid && out_byte == seen, "R8", int'(out_byte), int'(seen));
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = lfsr[0] | lfsr[1];
            if (out_valid) begin
                check(!in_ready, "R7", int'(in_ready), 0);
                if (out_byte != exp_b) bad_byte = 1;
                if (out_ready) begin
                    got++;
                    stalled = 0;
                end else begin
                    stalled = 1;
                    seen = out_byte;
                end
            end
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        check(!bad_byte, req, int'(out_byte), int'(exp_b));
        check(got == exp_n && !out_valid, req, got, exp_n);
        check(in_ready, "R7", int'(in_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10
        check(!out_valid && in_ready && !addr_err, "R10", int'({out_valid, in_ready, addr_err}), 2);
        rst_n = 1'b1;

        // R9: plain data once, several patterns
        for (int i = 0; i < 4; i++) begin
            send(8'h11 * (i + 1), 1'b1);
            collect(8'h11 * (i + 1), 1, "R9");
        end

        // R2/R3/R4: sweep every count
        for (int c = 0; c < 128; c++) begin
            send(8'(c), 1'b0);
            check(!out_valid, "R1", int'(out_valid), 0);
            send(8'((c * 3 + 1) & 255), 1'b1);
            if (c == 0)
                collect(8'(1), 1, "R3");
            else if (c == 127)
                collect(8'((127 * 3 + 1) & 255), 128, "R4");
            else
                collect(8'((c * 3 + 1) & 255), c + 1, "R2");
            if (c % 32 == 5) begin
                // R9: no pending count after a run
                send(8'hC3, 1'b1);
                collect(8'hC3, 1, "R9");
            end
        end

        // R6: newer count replaces the older one
        send(8'd5, 1'b0);
        send(8'd2, 1'b0);
        send(8'h5A, 1'b1);
        collect(8'h5A, 3, "R6");

        // R5: address command while idle
        send(8'h85, 1'b0);
        check(addr_err, "R5", int'(addr_err), 1);
        @(negedge clk);
        check(!addr_err && !out_valid, "R5", int'(addr_err), 0);
        send(8'h3C, 1'b1);
        collect(8'h3C, 1, "R5");

        // R5: address command while armed keeps the count
        send(8'd4, 1'b0);
        send(8'hFF, 1'b0);
        check(addr_err && !out_valid, "R5", int'(addr_err), 1);
        @(negedge clk);
        check(!addr_err, "R5", int'(addr_err), 0);
        send(8'h96, 1'b1);
        collect(8'h96, 5, "R5");

        finish_run();
    end
endmodule